// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs external memory cycles over one 16-bit bus that carries the address first and the data afterwards. A client inside the chip raises a request with an address, write data, two byte enables and a direction. The controller then runs one or two byte cycles on the pins and returns a one-clock acknowledge. Read data is valid on the cycle of that acknowledge. Each byte cycle opens with an address latch pulse and holds an active-low address-valid strobe for the whole cycle. The data phase uses a read strobe or a write strobe. There is no ready input. The data phase is stretched by a programmed count of zero to three wait states. Each wait state costs two clocks.

Three configuration inputs are sampled when a request is accepted: the bus width (8 or 16 bits), the write-pin function (plain write strobe or low-byte write strobe) and the wait count. In 8-bit mode a word access is split into two byte cycles, and the upper eight lines carry the high address byte throughout. Pin tristate control is reduced to two output enables, one for each byte lane.

Top module: `mux_bus_ctrl`

## Requirements
- R1: Under reset and directly after it, adv_n, rd_n and wr_n are high, ale, ack, ad_oe_lo and ad_oe_hi are low.
- R2: Every byte cycle starts with ale high for exactly one clock, with adv_n low, both output enables high, rd_n and wr_n high and the cycle address on ad_out. On the clock after ale falls, ad_out still holds that address with both enables high.
- R3: adv_n is low for exactly 4 + 2·W clocks per byte cycle, where W is cfg_waits (0..3). It goes high on the clock after the strobe ends and stays high for at least one clock between two byte cycles.
- R4: The data strobe (rd_n for reads, wr_n for writes) is low for exactly 2 + 2·W clocks, starting on the third clock of the byte cycle. rd_n and wr_n are never low together.
- R5: During rd_n low, ad_oe_lo is low, and ad_oe_hi is low in 16-bit mode. rdata holds the ad_in value present on the last clock of rd_n low. ack is a one-clock pulse on the first clock that adv_n is high after the final byte cycle. The requester must drop req in the ack clock, and a new request is accepted only once ack is low.
- R6: During a write strobe both output enables are high and ad_out is stable. In 16-bit mode it carries all of req_wdata. In 8-bit mode ad_out[7:0] carries the selected byte.
- R7: With cfg_wr_plain=1 and cfg_bus16=1, wr_n asserts for every write, whatever the byte enables.
- R8: With cfg_wr_plain=0 and cfg_bus16=1, wr_n asserts only when req_be[0]=1 (low-byte or word write). A high-byte-only write (req_be=2'b10) runs the full bus cycle with wr_n held high.
- R9: With cfg_bus16=0, wr_n asserts for every write regardless of cfg_wr_plain.
- R10: With cfg_bus16=0, ad_out[15:8] equals the address high byte and ad_oe_hi is high on every clock of the byte cycle, including the read strobe.
- R11: With cfg_bus16=0, byte enables 2'b11 (and 2'b00, which is treated as 2'b11) give two byte cycles: address with bit 0 cleared and the low byte first, then address with bit 0 set and the high byte. 2'b01 gives one cycle at the even address using lane 7:0. 2'b10 gives one cycle at the odd address using lane 15:8. Read bytes land in their own lane of rdata and any lane not read is zero.
- R12: With cfg_bus16=1, every request is one byte cycle with req_addr driven unmodified and a read returns all 16 bits of ad_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one state time is two clocks |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus16 | input | 1 | 1 = 16-bit data width, 0 = 8-bit |
| cfg_wr_plain | input | 1 | 1 = plain write strobe, 0 = low-byte write strobe |
| cfg_waits | input | 2 | Wait states added to the data phase (0..3) |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access byte address |
| req_wdata | input | 16 | Write data, byte lanes 15:8 and 7:0 |
| req_be | input | 2 | Byte enables, bit 0 = low lane |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| ad_out | output | 16 | Value driven on the shared bus |
| ad_in | input | 16 | Value sampled from the shared bus |
| ad_oe_lo | output | 1 | Output enable for lines 7:0 |
| ad_oe_hi | output | 1 | Output enable for lines 15:8 |
| ale | output | 1 | Address latch pulse, active high |
| adv_n | output | 1 | Address-valid strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe (plain or low-byte), active low |

## Verification
A sequencer stuck in the wrong state or with a bad wait counter shows up in the first affected byte cycle. It appears as an address-valid window or strobe width other than 4 + 2·W or 2 + 2·W clocks, or as a missing address latch pulse. A wrong lane pointer in 8-bit mode gives a wrong address bit 0, swapped write bytes or a read byte in the wrong rdata lane, all of which are visible at the ack of that same request. A wrong write-pin decision is visible in the strobe count of that byte cycle. Early release of the output enables is seen on the first clock of the read strobe.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ALE  = 3'd1,
    ST_HOLD = 3'd2,
    ST_STRB = 3'd3,
    ST_GAP  = 3'd4,
    ST_DONE = 3'd5
  } mbc_state_e;

  // A zero byte-enable is handled as a full word access.
  function automatic logic [1:0] mbc_norm_be(input logic [1:0] be);
    return (be == 2'b00) ? 2'b11 : be;
  endfunction

endpackage

// File: rtl/mbc_strobe_timer.sv
module mbc_strobe_timer #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic [WAIT_W-1:0] waits,
  output logic              last
);
  localparam int CNT_W = WAIT_W + 2;

  logic [CNT_W-1:0] cnt;

  // Loaded with 2*W+1 so the strobe state is held 2*W+2 clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CNT_W'({waits, 1'b1});
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/mbc_lane_plan.sv
module mbc_lane_plan #(
  parameter int BUS_W = 16
) (
  input  logic             bus16,
  input  logic             plain,
  input  logic [1:0]       be,
  input  logic [BUS_W-1:0] addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             lane,
  output logic             two_cycles,
  output logic             cur_hi,
  output logic [BUS_W-1:0] cyc_addr,
  output logic [BUS_W-1:0] cyc_wdata,
  output logic             wr_en
);
  localparam int BYTE_W = BUS_W / 2;

  logic [BYTE_W-1:0] sel_byte;

  always_comb begin
    two_cycles = !bus16 && (be == 2'b11);
    if (bus16)           cur_hi = 1'b0;
    else if (two_cycles) cur_hi = lane;
    else                 cur_hi = (be == 2'b10);

    sel_byte = cur_hi ? wdata[BUS_W-1:BYTE_W] : wdata[BYTE_W-1:0];

    if (bus16) begin
      cyc_addr  = addr;
      cyc_wdata = wdata;
    end else begin
      cyc_addr  = {addr[BUS_W-1:1], cur_hi};
      cyc_wdata = {addr[BUS_W-1:BYTE_W], sel_byte};
    end

    // Narrow bus: every write strobes. Wide bus: plain mode, or low lane enabled.
    wr_en = !bus16 || plain || be[0];
  end

endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       two_cycles,
  input  logic       tmr_last,
  output mbc_state_e state,
  output logic       lane,
  output logic       tmr_load,
  output logic       tmr_run
);
  mbc_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_ALE;
      ST_ALE:  nxt = ST_HOLD;
      ST_HOLD: nxt = ST_STRB;
      ST_STRB: if (tmr_last) nxt = (two_cycles && !lane) ? ST_GAP : ST_DONE;
      ST_GAP:  nxt = ST_ALE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign tmr_load = (state == ST_HOLD);
  assign tmr_run  = (state == ST_STRB);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      lane  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE)     lane <= 1'b0;
      else if (state == ST_GAP) lane <= 1'b1;
    end
  end

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bus16,
  input  logic              cfg_wr_plain,
  input  logic [WAIT_W-1:0] cfg_waits,
  input  logic              req,
  input  logic              req_we,
  input  logic [BUS_W-1:0]  req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [1:0]        req_be,
  output logic              ack,
  output logic [BUS_W-1:0]  rdata,
  output logic [BUS_W-1:0]  ad_out,
  input  logic [BUS_W-1:0]  ad_in,
  output logic              ad_oe_lo,
  output logic              ad_oe_hi,
  output logic              ale,
  output logic              adv_n,
  output logic              rd_n,
  output logic              wr_n
);
  localparam int BYTE_W = BUS_W / 2;

  mbc_state_e        state;
  logic              lane, tmr_load, tmr_run, tmr_last, start, accept;
  logic              two_cycles, cur_hi, wr_en;
  logic [BUS_W-1:0]  cyc_addr, cyc_wdata;

  // Request and configuration captured at acceptance.
  logic              t_we, t_bus16, t_plain;
  logic [WAIT_W-1:0] t_waits;
  logic [1:0]        t_be;
  logic [BUS_W-1:0]  t_addr, t_wdata;

  // Next values of the registered pins.
  logic              ale_nx, adv_nx, rd_nx, wr_nx, oe_lo_nx, oe_hi_nx, ack_nx;
  logic [BUS_W-1:0]  ad_nx;
  logic              cap;

  assign start  = req && !ack;
  assign accept = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      t_we    <= 1'b0;
      t_bus16 <= 1'b1;
      t_plain <= 1'b1;
      t_waits <= '0;
      t_be    <= 2'b11;
      t_addr  <= '0;
      t_wdata <= '0;
    end else if (accept) begin
      t_we    <= req_we;
      t_bus16 <= cfg_bus16;
      t_plain <= cfg_wr_plain;
      t_waits <= cfg_waits;
      t_be    <= mbc_norm_be(req_be);
      t_addr  <= req_addr;
      t_wdata <= req_wdata;
    end
  end

  mbc_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .two_cycles (two_cycles),
    .tmr_last   (tmr_last),
    .state      (state),
    .lane       (lane),
    .tmr_load   (tmr_load),
    .tmr_run    (tmr_run)
  );

  mbc_strobe_timer #(.WAIT_W(WAIT_W)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .load  (tmr_load),
    .run   (tmr_run),
    .waits (t_waits),
    .last  (tmr_last)
  );

  mbc_lane_plan #(.BUS_W(BUS_W)) u_plan (
    .bus16      (t_bus16),
    .plain      (t_plain),
    .be         (t_be),
    .addr       (t_addr),
    .wdata      (t_wdata),
    .lane       (lane),
    .two_cycles (two_cycles),
    .cur_hi     (cur_hi),
    .cyc_addr   (cyc_addr),
    .cyc_wdata  (cyc_wdata),
    .wr_en      (wr_en)
  );

  always_comb begin
    ale_nx   = 1'b0;
    adv_nx   = 1'b1;
    rd_nx    = 1'b1;
    wr_nx    = 1'b1;
    oe_lo_nx = 1'b0;
    oe_hi_nx = 1'b0;
    ack_nx   = 1'b0;
    ad_nx    = ad_out;
    unique case (state)
      ST_ALE, ST_HOLD: begin
        ale_nx   = (state == ST_ALE);
        adv_nx   = 1'b0;
        ad_nx    = cyc_addr;
        oe_lo_nx = 1'b1;
        oe_hi_nx = 1'b1;
      end
      ST_STRB: begin
        adv_nx = 1'b0;
        if (t_we) begin
          ad_nx    = cyc_wdata;
          oe_lo_nx = 1'b1;
          oe_hi_nx = 1'b1;
          wr_nx    = !wr_en;
        end else begin
          ad_nx    = cyc_addr;
          oe_hi_nx = !t_bus16;
          rd_nx    = 1'b0;
        end
      end
      ST_DONE: ack_nx = 1'b1;
      default: ;
    endcase
  end

  // Read data is taken on the edge where the read strobe deasserts.
  assign cap = !rd_n && rd_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale      <= 1'b0;
      adv_n    <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      ad_oe_lo <= 1'b0;
      ad_oe_hi <= 1'b0;
      ack      <= 1'b0;
      ad_out   <= '0;
      rdata    <= '0;
    end else begin
      ale      <= ale_nx;
      adv_n    <= adv_nx;
      rd_n     <= rd_nx;
      wr_n     <= wr_nx;
      ad_oe_lo <= oe_lo_nx;
      ad_oe_hi <= oe_hi_nx;
      ack      <= ack_nx;
      ad_out   <= ad_nx;
      if (accept) begin
        rdata <= '0;
      end else if (cap) begin
        if (t_bus16)     rdata <= ad_in;
        else if (cur_hi) rdata[BUS_W-1:BYTE_W] <= ad_in[BYTE_W-1:0];
        else             rdata[BYTE_W-1:0] <= ad_in[BYTE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/mbc_chk.sv
module mbc_chk #(
  parameter int BUS_W  = 16,
  parameter int WAIT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_bus16,
  input logic [WAIT_W-1:0] cfg_waits,
  input logic              ale,
  input logic              adv_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              ad_oe_lo,
  input logic              ad_oe_hi,
  input logic [BUS_W-1:0]  ad_out,
  input logic              ack
);
  localparam int CNT_W = WAIT_W + 4;

  logic              stb_idle;
  logic [CNT_W-1:0]  stb_cnt, adv_cnt;
  logic [WAIT_W-1:0] w_lat;
  logic              b16_lat;

  assign stb_idle = rd_n && wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_cnt <= '0;
      adv_cnt <= '0;
      w_lat   <= '0;
      b16_lat <= 1'b1;
    end else begin
      stb_cnt <= stb_idle ? '0 : stb_cnt + 1'b1;
      adv_cnt <= adv_n ? '0 : adv_cnt + 1'b1;
      if (ale) begin
        w_lat   <= cfg_waits;
        b16_lat <= cfg_bus16;
      end
    end
  end

  p_ale_one_clk_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  p_ale_frame_r2: assert property (@(posedge clk) disable iff (rst)
    ale |-> (!adv_n && ad_oe_lo && ad_oe_hi && rd_n && wr_n));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> ($stable(ad_out) && ad_oe_lo && ad_oe_hi));

  p_adv_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(adv_n) |-> (adv_cnt == CNT_W'(4 + 2 * w_lat)));

  p_stb_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(stb_idle) |-> (stb_cnt == CNT_W'(2 + 2 * w_lat)));

  p_stb_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  p_rd_release_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe_lo);

  p_ack_frame_r5: assert property (@(posedge clk) disable iff (rst)
    ack |-> (adv_n && rd_n && wr_n));

  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  p_hi_lane_r10: assert property (@(posedge clk) disable iff (rst)
    (!adv_n && !ale && !b16_lat) |-> ad_oe_hi);

endmodule

bind mux_bus_ctrl mbc_chk #(.BUS_W(BUS_W), .WAIT_W(WAIT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_bus16 (cfg_bus16),
  .cfg_waits (cfg_waits),
  .ale       (ale),
  .adv_n     (adv_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe_lo  (ad_oe_lo),
  .ad_oe_hi  (ad_oe_hi),
  .ad_out    (ad_out),
  .ack       (ack)
);

// File: tb/tb_mux_bus_ctrl.sv
module tb_mux_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_bus16 = 1'b1, cfg_wr_plain = 1'b1;
  logic [1:0]  cfg_waits = 2'd0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        ack, ad_oe_lo, ad_oe_hi, ale, adv_n, rd_n, wr_n;
  logic [15:0] rdata, ad_out, ad_in;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  mux_bus_ctrl dut (
    .clk(clk), .rst(rst), .cfg_bus16(cfg_bus16), .cfg_wr_plain(cfg_wr_plain),
    .cfg_waits(cfg_waits), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi),
    .ale(ale), .adv_n(adv_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic logic [15:0] mem_model(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + 8'h1D};
  endfunction

  // External memory model: answers only while the read strobe is low.
  logic [15:0] cur_a = '0;
  assign ad_in = rd_n ? 16'hDEAD : mem_model(cur_a);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // Bus monitor: one record per byte cycle.
  int          nrec = 0;
  logic [15:0] r_addr [4];
  logic [15:0] r_wd   [4];
  int          r_adv  [4];
  int          r_stb  [4];
  int          r_kind [4];
  int          r_ale  [4];
  bit          r_ale_ok [4];
  bit          r_oe_ok  [4];
  bit          r_wd_ok  [4];
  bit          r_hi_ok  [4];

  always @(negedge clk) begin
    int idx;
    if (!rst) begin
      if (ale && !$past(ale)) begin
        if (nrec < 4) begin
          r_addr[nrec] = ad_out; r_wd[nrec] = '0; r_adv[nrec] = 0; r_stb[nrec] = 0;
          r_kind[nrec] = 0; r_ale[nrec] = 0; r_oe_ok[nrec] = 1'b1; r_wd_ok[nrec] = 1'b1;
          r_hi_ok[nrec] = 1'b1;
          r_ale_ok[nrec] = ad_oe_lo && ad_oe_hi && !adv_n && rd_n && wr_n;
        end
        cur_a = ad_out;
        nrec++;
      end
      idx = nrec - 1;
      if (idx >= 0 && idx < 4) begin
        if (ale) r_ale[idx]++;
        if (!adv_n) begin
          r_adv[idx]++;
          if (!cfg_bus16 && (!ad_oe_hi || ad_out[15:8] != r_addr[idx][15:8])) r_hi_ok[idx] = 1'b0;
          if (!ale && !rd_n && !wr_n) r_oe_ok[idx] = 1'b0;
        end
        if (!rd_n) begin
          r_kind[idx] = 1; r_stb[idx]++;
          if (ad_oe_lo || (ad_oe_hi != !cfg_bus16)) r_oe_ok[idx] = 1'b0;
        end
        if (!wr_n) begin
          r_kind[idx] = 2;
          if (r_stb[idx] == 0) r_wd[idx] = ad_out;
          else if (ad_out != r_wd[idx]) r_wd_ok[idx] = 1'b0;
          r_stb[idx]++;
          if (!ad_oe_lo || !ad_oe_hi) r_oe_ok[idx] = 1'b0;
        end
      end
    end
  end

  task automatic run_txn(input bit b16, input bit plain, input logic [1:0] w,
                         input bit we, input logic [15:0] a, input logic [15:0] wd,
                         input logic [1:0] be);
    logic [1:0]  be_e;
    bit          two, got;
    int          ncyc, kind_e;
    logic [15:0] exp_rd, ea;
    string       wtag;
    @(negedge clk);
    cfg_bus16 = b16; cfg_wr_plain = plain; cfg_waits = w;
    req_we = we; req_addr = a; req_wdata = wd; req_be = be;
    nrec = 0;
    req = 1'b1;
    got = 1'b0;
    for (int t = 0; t < 100 && !got; t++) begin
      @(negedge clk);
      if (ack) got = 1'b1;
    end
    req = 1'b0;
    chk(got, "R5 ack seen", {31'd0, got}, 32'd1);
    be_e = (be == 2'b00) ? 2'b11 : be;
    two  = !b16 && (be_e == 2'b11);
    ncyc = two ? 2 : 1;
    exp_rd = '0;
    if (b16) exp_rd = mem_model(a);
    chk(nrec == ncyc, b16 ? "R12 cycle count" : "R11 cycle count", nrec, ncyc);
    if (!b16 && !(two && we == 1'b0)) ;
    for (int i = 0; i < ncyc && i < nrec; i++) begin
      bit hi;
      hi = two ? (i == 1) : (!b16 && be_e == 2'b10);
      ea = b16 ? a : {a[15:1], hi};
      chk(r_addr[i] == ea, b16 ? "R12 address" : "R11 address", r_addr[i], ea);
      chk(r_ale_ok[i] && r_ale[i] == 1, "R2 address phase", r_ale[i], 1);
      chk(r_adv[i] == 4 + 2 * w, "R3 adv_n width", r_adv[i], 4 + 2 * w);
      if (!we) kind_e = 1;
      else kind_e = (!b16 || plain || be_e[0]) ? 2 : 0;
      wtag = !we ? "R4 strobe kind" : (!b16 ? "R9 write strobe" : (plain ? "R7 write strobe" : "R8 write strobe"));
      chk(r_kind[i] == kind_e, wtag, r_kind[i], kind_e);
      chk(r_stb[i] == (kind_e != 0 ? 2 + 2 * w : 0), "R4 strobe width", r_stb[i],
          kind_e != 0 ? 2 + 2 * w : 0);
      chk(r_oe_ok[i], we ? "R6 enables" : "R5 enables released", r_oe_ok[i], 1);
      if (we && kind_e == 2) begin
        logic [15:0] exp_wd, act_wd;
        exp_wd = b16 ? wd : {8'h00, hi ? wd[15:8] : wd[7:0]};
        act_wd = b16 ? r_wd[i] : {8'h00, r_wd[i][7:0]};
        chk(r_wd_ok[i] && act_wd == exp_wd, "R6 write data", act_wd, exp_wd);
      end
      if (!b16) begin
        chk(r_hi_ok[i], "R10 high address lane", r_hi_ok[i], 1);
        if (hi) exp_rd[15:8] = mem_model(ea)[7:0];
        else    exp_rd[7:0]  = mem_model(ea)[7:0];
      end
    end
    chk(adv_n == 1'b1, "R5 ack with adv_n high", adv_n, 1);
    if (!we) chk(rdata == exp_rd, b16 ? "R5 read data" : "R11 read lanes", rdata, exp_rd);
    @(negedge clk);
    chk(ack == 1'b0, "R5 ack one clock", ack, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(adv_n && rd_n && wr_n && !ale && !ack && !ad_oe_lo && !ad_oe_hi, "R1 in reset",
        {adv_n, rd_n, wr_n, ale, ack, ad_oe_lo, ad_oe_hi}, 7'b1110000);
    rst = 1'b0;
    @(negedge clk);
    chk(adv_n && rd_n && wr_n && !ale && !ack && !ad_oe_lo && !ad_oe_hi, "R1 after reset",
        {adv_n, rd_n, wr_n, ale, ack, ad_oe_lo, ad_oe_hi}, 7'b1110000);

    // Directed corners: every width, write-pin mode, wait extreme and byte-enable pattern.
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 2; p++)
        for (int wi = 0; wi < 2; wi++)
          for (int e = 0; e < 4; e++) begin
            run_txn(b[0], p[0], wi ? 2'd3 : 2'd0, 1'b1, 16'h3A55 + 16'(e), 16'hB7C4 ^ 16'(e), e[1:0]);
            run_txn(b[0], p[0], wi ? 2'd3 : 2'd0, 1'b0, 16'hC0F0 + 16'(e), 16'h0, e[1:0]);
          end

    // Random mix.
    for (int k = 0; k < 60; k++) begin
      logic [31:0] r;
      r = $urandom;
      run_txn(r[0], r[1], r[3:2], r[4], 16'($urandom), 16'($urandom), r[6:5]);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule